// File: doc/BRIEF.md
# CAN Controller Bus-Join Sequencer

This block decides when a CAN controller may take part in bus traffic. After a hardware reset, or whenever software raises its reset-request level, the controller sits in configuration mode. Software then lowers the request and programs the two bit-timing registers. The sequencer notes each of those writes.

Once both writes have been seen, a fixed countdown of 23 system clocks runs. When it ends, the reset-status flag drops and the block moves to a waiting mode. In the waiting mode it watches the sampled receive bit on each bit-time strobe. After eleven recessive samples in a row, the bus is taken to be idle and the block enters normal operation.

Until normal operation is reached, the transmit line is held recessive. The surrounding controller reads the mode output to gate its framing and arbitration logic.

Top module: `can_join_seq`

## Requirements
- R1: After the asynchronous hardware reset, mode is 2'b00 (configuration), in_reset is 1 and tx_out is 1.
- R2: When rst_req is 1 at a clock edge, mode is 2'b00 and in_reset is 1 after that edge, from any mode. This holds for as long as rst_req stays 1, and timing-register writes made during that time are not remembered.
- R3: With rst_req at 0, once both timing registers have been written, in_reset falls and mode becomes 2'b01 exactly 23 clock edges after the edge that accepted the second write. The two writes may come in either order, in separate cycles or together in one cycle.
- R4: If only one of the two timing registers has been written, the block stays in mode 2'b00 with in_reset at 1.
- R5: A write to either timing register while the 23-clock countdown runs restarts the countdown, so that the exit happens 23 edges after that latest write.
- R6: In mode 2'b01, each edge with bit_tick at 1 samples rx_bit, where 1 means recessive and 0 means dominant. Mode becomes 2'b10 at the edge of the eleventh consecutive recessive sample. A dominant sample restarts the count from zero.
- R7: rx_bit is ignored on edges where bit_tick is 0. Strobes received in mode 2'b00 do not count toward the eleven recessive samples.
- R8: tx_out is 1 in modes 2'b00 and 2'b01. In mode 2'b10 it follows tx_in.
- R9: The mode output takes only the codes 00 (configuration), 01 (waiting for bus idle) and 10 (normal). Code 11 never appears.
- R10: After a reset request from mode 2'b01 or 2'b10, both timing registers must be written again before the block can leave configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| rst_req | input | 1 | Software reset-request level |
| btr0_wr | input | 1 | Write strobe of the first bit-timing register |
| btr1_wr | input | 1 | Write strobe of the second bit-timing register |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| bit_tick | input | 1 | One-clock strobe marking a bit-time sample point |
| tx_in | input | 1 | Transmit bit from the framing logic |
| tx_out | output | 1 | Transmit bit toward the transceiver |
| mode | output | 2 | Current mode: 00 configuration, 01 waiting, 10 normal |
| in_reset | output | 1 | Reset procedure still in progress |

## Verification
The countdown is swept over three write orders (first register first, second register first, both in one cycle) and several gaps between the two writes. The mode is sampled exactly on edge 22 and edge 23 after the second write. This separates a correct delay from an off-by-one, and a trigger on either write from a trigger on both.

Restart writes are placed early, in the middle and at the last cycle of the countdown. This shows that the delay is re-armed rather than merely extended.

The idle detector is fed every recessive prefix length from zero to ten, followed by one dominant sample and then eleven recessive ones. Dominant values are placed between strobes, and recessive strobes are sent during configuration. Together these tell a true consecutive count apart from a total count, a per-clock count, or a count that leaks across modes.

Reset requests are issued during the countdown, during waiting and during normal operation. Each is followed by a single timing-register write, which confirms that the written flags were cleared.

// File: rtl/can_join_pkg.sv
package can_join_pkg;

    typedef enum logic [1:0] {
        MODE_CFG  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_RUN  = 2'b10
    } mode_e;

endpackage

// File: rtl/can_join_cfg_timer.sv
// Tracks the two timing-register writes and runs the settle countdown.
module can_join_cfg_timer #(
    parameter int DELAY_CLKS = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic wr0,
    input  logic wr1,
    output logic done
);
    localparam int CW = $clog2(DELAY_CLKS + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DELAY_CLKS - 1);

    typedef struct packed {
        logic          seen0;
        logic          seen1;
        logic          armed;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = 1'b0;
        if (!active) begin
            tmr_d = '0;
        end else begin
            tmr_d.seen0 = tmr_q.seen0 | wr0;
            tmr_d.seen1 = tmr_q.seen1 | wr1;
            if (tmr_q.armed) begin
                if (wr0 || wr1) begin
                    tmr_d.cnt = RELOAD;
                end else if (tmr_q.cnt == '0) begin
                    done = 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt - 1'b1;
                end
            end else if (tmr_d.seen0 && tmr_d.seen1) begin
                tmr_d.armed = 1'b1;
                tmr_d.cnt   = RELOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/can_join_idle_det.sv
// Counts consecutive recessive samples taken on bit-time strobes.
module can_join_idle_det #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic rx,
    output logic idle
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        idle  = 1'b0;
        if (!active) begin
            det_d.run = '0;
        end else if (tick) begin
            if (!rx) begin
                det_d.run = '0;
            end else if (det_q.run == LAST) begin
                idle = 1'b1;
            end else begin
                det_d.run = det_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/can_join_seq.sv
module can_join_seq #(
    parameter int DELAY_CLKS = 23,
    parameter int IDLE_BITS  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       btr0_wr,
    input  logic       btr1_wr,
    input  logic       rx_bit,
    input  logic       bit_tick,
    input  logic       tx_in,
    output logic       tx_out,
    output logic [1:0] mode,
    output logic       in_reset
);
    import can_join_pkg::*;

    typedef struct packed {
        mode_e mode;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tmr_active, tmr_done;
    logic det_active, det_idle;

    assign tmr_active = (seq_q.mode == MODE_CFG)  && !rst_req;
    assign det_active = (seq_q.mode == MODE_WAIT) && !rst_req;

    can_join_cfg_timer #(.DELAY_CLKS(DELAY_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (tmr_active),
        .wr0    (btr0_wr),
        .wr1    (btr1_wr),
        .done   (tmr_done)
    );

    can_join_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (det_active),
        .tick   (bit_tick),
        .rx     (rx_bit),
        .idle   (det_idle)
    );

    always_comb begin
        seq_d = seq_q;
        if (rst_req) begin
            seq_d.mode = MODE_CFG;
        end else begin
            unique case (seq_q.mode)
                MODE_CFG:  if (tmr_done) seq_d.mode = MODE_WAIT;
                MODE_WAIT: if (det_idle) seq_d.mode = MODE_RUN;
                MODE_RUN:  seq_d.mode = MODE_RUN;
                default:   seq_d.mode = MODE_CFG;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.mode <= MODE_CFG;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode     = seq_q.mode;
    assign in_reset = (seq_q.mode == MODE_CFG);
    assign tx_out   = (seq_q.mode == MODE_RUN) ? tx_in : 1'b1;

endmodule

// File: rtl/can_join_seq_chk.sv
module can_join_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_req,
    input logic       btr0_wr,
    input logic       btr1_wr,
    input logic       bit_tick,
    input logic       tx_in,
    input logic       tx_out,
    input logic [1:0] mode,
    input logic       in_reset
);

    a_r2_req_forces_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (mode == 2'b00 && in_reset));

    a_r9_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    a_r8_tx_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |-> tx_out);

    a_r8_tx_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (tx_out == tx_in));

    a_r5_write_holds_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && (btr0_wr || btr1_wr)) |=> mode == 2'b00);

    a_r3_cfg_not_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> mode != 2'b10);

    a_r7_wait_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !bit_tick && !rst_req) |=> mode == 2'b01);

endmodule

bind can_join_seq can_join_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .btr0_wr  (btr0_wr),
    .btr1_wr  (btr1_wr),
    .bit_tick (bit_tick),
    .tx_in    (tx_in),
    .tx_out   (tx_out),
    .mode     (mode),
    .in_reset (in_reset)
);

// File: tb/can_join_seq_bench.sv
module can_join_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0;
    logic       btr0_wr = 1'b0;
    logic       btr1_wr = 1'b0;
    logic       rx_bit = 1'b1;
    logic       bit_tick = 1'b0;
    logic       tx_in = 1'b0;
    logic       tx_out;
    logic [1:0] mode;
    logic       in_reset;

    int n_chk = 0;
    int n_fail = 0;

    can_join_seq u_can_join_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_req  (rst_req),
        .btr0_wr  (btr0_wr),
        .btr1_wr  (btr1_wr),
        .rx_bit   (rx_bit),
        .bit_tick (bit_tick),
        .tx_in    (tx_in),
        .tx_out   (tx_out),
        .mode     (mode),
        .in_reset (in_reset)
    );

    always #2 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input int exp);
        chk(req, int'(mode), exp);
        chk({req, "/R9"}, int'(mode == 2'b11), 0);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0; rst_req = 1'b0; btr0_wr = 1'b0; btr1_wr = 1'b0;
        bit_tick = 1'b0; rx_bit = 1'b1;
        steps(2);
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input logic a, input logic b);
        btr0_wr = a; btr1_wr = b;
        step();
        btr0_wr = 1'b0; btr1_wr = 1'b0;
    endtask

    // bit sample: strobe edge, then two dominant clocks that must be ignored (R7)
    task automatic send_bit(input logic b);
        rx_bit = b; bit_tick = 1'b1;
        step();
        bit_tick = 1'b0; rx_bit = 1'b0;
        steps(2);
    endtask

    task automatic goto_wait();
        hw_reset();
        wr(1'b1, 1'b1);
        steps(23);
    endtask

    task automatic goto_run();
        goto_wait();
        for (int i = 0; i < 11; i++) send_bit(1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        #1;
        chk("R1 mode in reset", int'(mode), 0);
        chk("R1 in_reset", int'(in_reset), 1);
        chk("R1 tx_out", int'(tx_out), 1);

        // R3 sweep over write order and gap
        for (int ord = 0; ord < 3; ord++) begin
            for (int gap = 0; gap < 4; gap++) begin
                hw_reset();
                if (ord == 2) begin
                    wr(1'b1, 1'b1);
                end else begin
                    wr(ord == 0, ord == 1);
                    steps(gap);
                    chk_mode("R4 one write only", 0);
                    wr(ord == 1, ord == 0);
                end
                steps(22);
                chk_mode("R3 edge 22 still cfg", 0);
                chk("R3 in_reset at 22", int'(in_reset), 1);
                step();
                chk_mode("R3 edge 23 waiting", 1);
                chk("R3 in_reset at 23", int'(in_reset), 0);
            end
        end

        // R4 a single register written, long wait
        hw_reset();
        wr(1'b0, 1'b1);
        wr(1'b0, 1'b1);
        steps(60);
        chk_mode("R4 only second reg", 0);

        // R5 restart at several points of the countdown
        for (int r = 1; r <= 22; r += 7) begin
            hw_reset();
            wr(1'b1, 1'b1);
            steps(r - 1);
            wr(1'b1, 1'b0);
            steps(22);
            chk_mode("R5 restarted edge 22", 0);
            step();
            chk_mode("R5 restarted edge 23", 1);
        end

        // R2 writes while request held are not remembered
        hw_reset();
        rst_req = 1'b1;
        wr(1'b1, 1'b1);
        rst_req = 1'b0;
        steps(40);
        chk_mode("R2 writes under request dropped", 0);

        // R2 request during countdown
        hw_reset();
        wr(1'b1, 1'b1);
        steps(10);
        rst_req = 1'b1; step(); rst_req = 1'b0;
        chk_mode("R2 request in countdown", 0);
        steps(30);
        chk_mode("R2 countdown abandoned", 0);

        // R6 dominant restart sweep, recessive strobes during countdown (R7)
        for (int pre = 0; pre <= 10; pre++) begin
            hw_reset();
            wr(1'b1, 1'b1);
            for (int k = 0; k < 7; k++) send_bit(1'b1);
            steps(2);
            chk_mode("R7 waiting after countdown", 1);
            for (int k = 0; k < pre; k++) send_bit(1'b1);
            send_bit(1'b0);
            for (int k = 0; k < 10; k++) send_bit(1'b1);
            chk_mode("R6 ten recessive still waiting", 1);
            send_bit(1'b1);
            chk_mode("R6 eleventh recessive normal", 2);
        end

        // R6 exact edge of the eleventh sample
        goto_wait();
        for (int k = 0; k < 10; k++) send_bit(1'b1);
        rx_bit = 1'b1; bit_tick = 1'b1;
        step();
        bit_tick = 1'b0;
        chk_mode("R6 normal right after eleventh strobe edge", 2);

        // R7 recessive line without strobes does not count
        goto_wait();
        rx_bit = 1'b1;
        steps(50);
        chk_mode("R7 no strobe no progress", 1);

        // R8 transmit behaviour
        goto_wait();
        tx_in = 1'b0; #0.5;
        chk("R8 tx recessive while waiting", int'(tx_out), 1);
        goto_run();
        for (int v = 0; v < 2; v++) begin
            tx_in = v[0]; #0.5;
            chk("R8 tx follows in normal", int'(tx_out), v);
        end
        hw_reset();
        tx_in = 1'b0; #0.5;
        chk("R8 tx recessive in cfg", int'(tx_out), 1);

        // R2 and R10 request from waiting and normal
        for (int src = 0; src < 2; src++) begin
            if (src == 0) goto_wait(); else goto_run();
            rst_req = 1'b1; step();
            chk_mode("R2 request from running modes", 0);
            chk("R2 in_reset", int'(in_reset), 1);
            rst_req = 1'b0;
            wr(1'b1, 1'b0);
            steps(40);
            chk_mode("R10 single rewrite not enough", 0);
            wr(1'b0, 1'b1);
            steps(23);
            chk_mode("R10 rewrite both exits", 1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule